// File: doc/BRIEF.md
# Deep Sleep Backup Register File

This block holds a small bank of general-purpose backup registers that keep their contents through deep sleep and through most resets. Firmware saves critical context here before it powers the core down, then reads it back after wake-up. A register takes a new value only after the same data has been written to it twice. This guards the contents against a single stray write.

Each register keeps a committed value, a pending value and an armed flag. The first write loads the pending value and arms the register. A matching second write commits the value. The two writes may be separated by idle cycles or by writes to other registers. Reads always return the committed value.

Loss of contents depends on the event that occurs. A deep-sleep brown-out or supply collapse wipes every register unless the backup supply is present. An external master-clear keeps the contents. Every event cancels a half-finished write pair.

Top module: `bkup_regfile`

## Requirements
- R1: When reset is released after a power-up reset taken with `bat_ok` low, every register reads 0x00 and no register is armed.
- R2: A single write to a register does not change the value read from it.
- R3: A second write of the same data to an armed register commits it. The new value is readable from the cycle after that write, and the register is then disarmed.
- R4: Idle cycles between the first and second write do not prevent the commit.
- R5: A second write with different data does not commit. It replaces the pending value, so a following write of that newer data commits it.
- R6: A write to one register address leaves the armed state and pending value of every other register unchanged.
- R7: `rd_data` shows the committed value of the register selected by `rd_addr`, never a pending value.
- R8: A `brownout_evt` pulse while `bat_ok` is low clears every register to 0x00 and disarms all of them.
- R9: A `brownout_evt` pulse while `bat_ok` is high keeps every committed value.
- R10: A `mclr_evt` pulse keeps every committed value and disarms every register, so the next single write does not commit.
- R11: A reset taken while `bat_ok` is high keeps every committed value and disarms every register.
- R12: A write in the same cycle as `brownout_evt` or `mclr_evt` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| bat_ok | input | 1 | Backup supply present; protects the contents |
| brownout_evt | input | 1 | Deep-sleep brown-out or supply-collapse pulse |
| mclr_evt | input | 1 | External master-clear pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (2) | Register selected for the write |
| wr_data | input | DATA_W (8) | Write data |
| rd_addr | input | ADDR_W (2) | Register selected for the read |
| rd_data | output | DATA_W (8) | Committed value of the selected register |

## Verification
The bench uses the default build: four registers of eight bits each. With this build, every address is exercised, including the highest one. It also allows a write pair on one register to be interleaved with a full pair on another. All four registers can be read back after each wipe-or-keep event, so a lost or wrongly cleared register becomes visible at the read port.

// File: rtl/bkup_pkg.sv
// Package: shared types for the backup register file.
// Assumes: event pulses are already synchronous to clk.
package bkup_pkg;
    // Per-register event controls from the event decoder.
    typedef struct packed {
        logic wipe;   // clear committed, pending and armed
        logic abort;  // cancel a half-finished write pair
    } evt_ctl_t;
endpackage

// File: rtl/bkup_evt_ctl.sv
// Module: bkup_evt_ctl
// Converts the event inputs into wipe and abort controls.
// Assumes: a brown-out is destructive only when the backup supply is absent;
// every event cancels any pending write pair.
module bkup_evt_ctl
    import bkup_pkg::*;
(
    input  logic     bat_ok,
    input  logic     brownout_evt,
    input  logic     mclr_evt,
    output evt_ctl_t ctl
);
    // Purpose: derive wipe/abort from the event and supply state.
    always_comb begin
        ctl.wipe  = brownout_evt && !bat_ok;
        ctl.abort = brownout_evt || mclr_evt;
    end
endmodule

// File: rtl/bkup_cell.sv
// Module: bkup_cell
// One backup register with double-write commit.
// Assumes: wr_hit is already qualified by the address; the reset is power-up
// only and spares the committed value when keep_on_rst is high.
module bkup_cell
    import bkup_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_on_rst,
    input  evt_ctl_t          ctl,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] committed
);
    logic              armed;
    logic [DATA_W-1:0] pending;
    logic              match;

    // Purpose: detect a confirming second write.
    always_comb match = armed && (wr_data == pending);

    // Purpose: track committed value, pending value and armed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            pending <= '0;
            if (!keep_on_rst) committed <= '0;
        end else if (ctl.wipe) begin
            armed     <= 1'b0;
            pending   <= '0;
            committed <= '0;
        end else if (ctl.abort) begin
            armed <= 1'b0;
        end else if (wr_hit) begin
            if (match) begin
                committed <= wr_data;
                armed     <= 1'b0;
            end else begin
                pending <= wr_data;
                armed   <= 1'b1;
            end
        end
    end

    // R3: a confirmed write lands in the committed value and disarms.
    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !ctl.abort && armed && wr_data == pending)
        |=> (committed == $past(wr_data)) && !armed);

    // R2: a first write only arms; the committed value holds.
    a_r2_first_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !ctl.abort && !armed)
        |=> armed && $stable(committed) && (pending == $past(wr_data)));

    // R6: without a hit or an event, the cell's state holds.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !ctl.abort)
        |=> $stable(armed) && $stable(pending) && $stable(committed));

    // R8: a wipe clears everything.
    a_r8_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wipe |=> (committed == '0) && !armed);

    // R10: a non-destructive event disarms and keeps the contents.
    a_r10_abort_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.abort && !ctl.wipe) |=> !armed && $stable(committed));
endmodule

// File: rtl/bkup_rd_mux.sv
// Module: bkup_rd_mux
// Selects one committed value for the read port.
// Assumes: an address beyond the bank returns zero.
module bkup_rd_mux #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [ADDR_W-1:0]               sel,
    output logic [DATA_W-1:0]               dout
);
    // Purpose: pick the selected register.
    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == ADDR_W'(i)) dout = regs[i];
        end
    end
endmodule

// File: rtl/bkup_regfile.sv
// Module: bkup_regfile (top)
// Bank of backup registers that survive deep sleep, with double-write commit
// and contents kept or wiped by event cause.
// Assumes: all inputs are synchronous to clk; reads are combinational.
module bkup_regfile
    import bkup_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bat_ok,
    input  logic              brownout_evt,
    input  logic              mclr_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    evt_ctl_t                        ctl;
    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    bkup_evt_ctl u_evt (
        .bat_ok       (bat_ok),
        .brownout_evt (brownout_evt),
        .mclr_evt     (mclr_evt),
        .ctl          (ctl)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        // Purpose: decode the write address for this register.
        always_comb hit[g] = wr_en && (wr_addr == ADDR_W'(g));

        bkup_cell #(.DATA_W(DATA_W)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .keep_on_rst (bat_ok),
            .ctl         (ctl),
            .wr_hit      (hit[g]),
            .wr_data     (wr_data),
            .committed   (regs[g])
        );
    end

    bkup_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .regs (regs),
        .sel  (rd_addr),
        .dout (rd_data)
    );

    // R6: at most one register is addressed by any write.
    a_r6_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R9: a brown-out with the backup supply present keeps the read value.
    a_r9_bat_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (brownout_evt && bat_ok) ##1 $stable(rd_addr) |-> $stable(rd_data));
endmodule

// File: tb/sim_bkup_regfile.sv
module sim_bkup_regfile;
    localparam int  CLK_PERIOD = 10;
    localparam int  NV         = 27;
    // Entry: {req[3:0], kind[1:0], addr[1:0], data[7:0]}; kind 0 write, 1 check, 2 idle.
    localparam logic [15:0] VEC [NV] = '{
        16'h1400,                                            // R1 reset value
        16'h2011, 16'h2400,                                  // R2 single write
        16'h3011, 16'h3411,                                  // R3 confirm
        16'h4122, 16'h4800, 16'h4800, 16'h4500, 16'h4122, 16'h4522, // R4 gap
        16'h5233, 16'h5244, 16'h5600, 16'h5244, 16'h5644,   // R5 mismatch
        16'h6355, 16'h6066, 16'h6066, 16'h6466, 16'h6355, 16'h6755, // R6 interleave
        16'h7077, 16'h7466,                                  // R7 pending hidden
        16'h5099, 16'h5099, 16'h5499                         // R5 replace pending
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bat_ok = 1'b0;
    logic       brownout_evt = 1'b0;
    logic       mclr_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkup_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bat_ok(bat_ok), .brownout_evt(brownout_evt),
        .mclr_evt(mclr_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input logic [1:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s reg%0d actual=%02h expected=%02h", req, a, rd_data, exp);
        end
    endtask

    task automatic write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input bit bo, input bit mc);
        @(negedge clk);
        brownout_evt = bo; mclr_evt = mc;
        @(negedge clk);
        brownout_evt = 1'b0; mclr_evt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Table walk: R1..R7
        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [1:0] kd;
            logic [1:0] ad;
            logic [7:0] dt;
            {rq, kd, ad, dt} = VEC[i];
            case (kd)
                2'd0: begin
                    @(negedge clk);
                    wr_addr = ad; wr_data = dt; wr_en = 1'b1;
                    @(negedge clk);
                    wr_en = 1'b0;
                end
                2'd1: check(ad, dt, $sformatf("R%0d step %0d", rq, i));
                default: @(negedge clk);
            endcase
        end
        // State now: 99, 22, 44, 55.
        // R9: brown-out with backup supply keeps everything.
        bat_ok = 1'b1;
        pulse(1'b1, 1'b0);
        check(2'd0, 8'h99, "R9");
        check(2'd1, 8'h22, "R9");
        check(2'd2, 8'h44, "R9");
        check(2'd3, 8'h55, "R9");
        // R10: master-clear keeps contents and cancels the half pair.
        write(2'd1, 8'hAA);
        pulse(1'b0, 1'b1);
        check(2'd1, 8'h22, "R10");
        write(2'd1, 8'hAA);
        check(2'd1, 8'h22, "R10");
        write(2'd1, 8'hAA);
        check(2'd1, 8'hAA, "R3");
        // R3: after commit the register is disarmed.
        write(2'd1, 8'hBB);
        check(2'd1, 8'hAA, "R3");
        write(2'd1, 8'hBB);
        check(2'd1, 8'hBB, "R3");
        // R12: a write coinciding with an event is dropped.
        write(2'd3, 8'hC3);
        @(negedge clk);
        wr_addr = 2'd3; wr_data = 8'hC3; wr_en = 1'b1; brownout_evt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; brownout_evt = 1'b0;
        check(2'd3, 8'h55, "R12");
        write(2'd3, 8'hC3);
        check(2'd3, 8'h55, "R12");
        // R11: reset with backup supply keeps contents and disarms.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(2'd0, 8'h99, "R11");
        check(2'd3, 8'h55, "R11");
        write(2'd3, 8'hC3);
        check(2'd3, 8'h55, "R11");
        // R8: brown-out without backup supply wipes everything.
        bat_ok = 1'b0;
        pulse(1'b1, 1'b0);
        check(2'd0, 8'h00, "R8");
        check(2'd1, 8'h00, "R8");
        check(2'd2, 8'h00, "R8");
        check(2'd3, 8'h00, "R8");
        write(2'd3, 8'hC3);
        check(2'd3, 8'h00, "R8");
        // R1: power-up reset without supply zeroes the bank.
        write(2'd2, 8'h5A);
        write(2'd2, 8'h5A);
        check(2'd2, 8'h5A, "R4");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(2'd2, 8'h00, "R1");
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule